// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the configuration of a set of functional units. Each configuration register has two stages of equal width. The front stage receives new values. The back stage drives the functional logic through the `cfg_active` bus. A host port loads front stages over a plain address/data/write-strobe bus. One extra address holds an update-control register, which picks one of two modes. In transparent mode a host write goes to both stages at once. In held mode a host write lands in the front stage only, and the running configuration stays as it was until a global commit copies every front stage into its back stage on one clock edge.

A download engine fills front stages through a separate parallel load port. It then raises `dl_commit` to make the loaded set active. The update-control register also carries an erase-enable bit. This bit gates page-erase requests on their way to the nonvolatile store. The store itself performs the erase and sets every bit of the page to 1.

Top module: `dbuf_cfg_bank`

## Requirements
- R1: On a clock edge with `rst_n` low, every front and back stage clears to zero, the update-control register clears (transparent = 0, erase enable = 0, no commit pending) and `erase_go` clears.
- R2: When control bit 0 (transparent) is 1, a host write to register address i < NUM_REGS sets both stages of register i on that edge, so `cfg_active` slice i shows the data right after that edge.
- R3: When control bit 0 is 0, a host write changes only the front stage, and `cfg_active` does not change on that edge unless a commit also happens on it.
- R4: A host write to control address NUM_REGS with data bit 1 set raises an internal commit pulse for exactly one cycle. On the edge that ends that cycle, every back stage takes its front-stage value.
- R5: Control bit 1 always reads back as 0. A commit is never left pending after its pulse cycle.
- R6: If a host write and a commit land on the same edge, the back stages receive the front values from before the write. In held mode the written value stays in the front stage only. In transparent mode the written register's back stage takes the written value.
- R7: A load-port write sets only the front stage of the addressed register. A host write to the same register on the same edge overrides it. `dl_commit` high on an edge copies every front stage into its back stage on that edge.
- R8: While control bit 2 (erase enable) is 1, an `erase_cmd` raises `erase_go` one edge later with `erase_page_q` equal to the requested page. While bit 2 is 0, `erase_cmd` is ignored: `erase_go` stays 0 and `erase_page_q` stays 0.
- R9: `host_rdata` is combinational. For address i < NUM_REGS it returns the back stage of register i. For address NUM_REGS it returns {zeros, erase enable, 0, transparent}. For any higher address it returns zero, and host writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address; NUM_REGS selects the update-control register |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Back stage or control value at host_addr |
| dl_wr | input | 1 | Load-port write strobe (front stage only) |
| dl_addr | input | ADDR_W | Load-port register address |
| dl_data | input | DATA_W | Load-port data |
| dl_commit | input | 1 | Copies all front stages to back stages on this edge |
| erase_cmd | input | 1 | Page-erase request |
| erase_page | input | PAGE_W | Page addressed by the erase request |
| erase_go | output | 1 | Gated erase strobe to the nonvolatile store |
| erase_page_q | output | PAGE_W | Page accompanying erase_go, zero otherwise |
| cfg_active | output | NUM_REGS*DATA_W | All back stages, register i in bits [i*DATA_W +: DATA_W] |

## Verification
A host write in transparent mode and a `dl_commit` both show up on `cfg_active` and `host_rdata` right after the edge that samples them. A commit requested through control bit 1 shows up one edge later, because the pulse register sits in between. `erase_go` follows `erase_cmd` by one edge. The bench drives each stimulus on a falling edge and steps its reference model on the next rising edge. It compares all outputs on the falling edge after that, so every result is checked half a cycle after the edge that should have produced it. The commit case is therefore caught on the second comparison after the control write.

// File: rtl/dbuf_cfg_pkg.sv
// Shared definitions for the double-buffered configuration bank.
// Assumes the data word is at least three bits wide so the control bits fit.
package dbuf_cfg_pkg;

    localparam int CTRL_TRANSP_BIT = 0;
    localparam int CTRL_COMMIT_BIT = 1;
    localparam int CTRL_ERASE_BIT  = 2;
    localparam int CTRL_BITS       = 3;

    typedef struct packed {
        logic erase_en;
        logic transparent;
    } upd_ctrl_t;

endpackage

// File: rtl/dbuf_stage_pair.sv
// One configuration register made of a front stage and a back stage.
// The front stage takes host or load data, with the host winning a collision.
// The back stage takes host data directly in transparent mode; otherwise it
// takes the front value (from before this edge) on a commit.
module dbuf_stage_pair #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_d,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_d,
    input  logic              commit,
    input  logic              transparent,
    output logic [DATA_W-1:0] front_q,
    output logic [DATA_W-1:0] back_q
);

    // Front stage: host write first, load port second.
    always_ff @(posedge clk) begin
        if (!rst_n)        front_q <= '0;
        else if (host_we)  front_q <= host_d;
        else if (load_we)  front_q <= load_d;
    end

    // Back stage: write-through in transparent mode, else copy on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       back_q <= '0;
        else if (host_we && transparent)  back_q <= host_d;
        else if (commit)                  back_q <= front_q;
    end

endmodule

// File: rtl/dbuf_upd_ctrl.sv
// Update-control register: transparent-mode bit, self-clearing commit bit and
// erase-enable bit. The commit bit is never stored; a write of 1 produces a
// one-cycle pulse and the bit reads as 0.
module dbuf_upd_ctrl
    import dbuf_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic [CTRL_BITS-1:0] ctrl_d,
    output upd_ctrl_t            ctrl_q,
    output logic                 commit_pulse,
    output logic [CTRL_BITS-1:0] ctrl_rd
);

    // Holds the mode and erase-enable bits across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.transparent <= ctrl_d[CTRL_TRANSP_BIT];
            ctrl_q.erase_en    <= ctrl_d[CTRL_ERASE_BIT];
        end
    end

    // Produces the one-cycle global commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_pulse <= 1'b0;
        else        commit_pulse <= ctrl_we && ctrl_d[CTRL_COMMIT_BIT];
    end

    // Read view: the commit bit always reads as zero.
    always_comb begin
        ctrl_rd                  = '0;
        ctrl_rd[CTRL_TRANSP_BIT] = ctrl_q.transparent;
        ctrl_rd[CTRL_ERASE_BIT]  = ctrl_q.erase_en;
    end

endmodule

// File: rtl/dbuf_erase_gate.sv
// Passes page-erase requests on to the nonvolatile store only while erase is
// enabled. It adds one register stage and drives the page as zero when idle.
module dbuf_erase_gate #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_en,
    input  logic              req,
    input  logic [PAGE_W-1:0] req_page,
    output logic              go,
    output logic [PAGE_W-1:0] go_page
);

    // Registers the gated request together with its page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go      <= 1'b0;
            go_page <= '0;
        end else begin
            go      <= req && erase_en;
            go_page <= (req && erase_en) ? req_page : '0;
        end
    end

endmodule

// File: rtl/dbuf_cfg_bank.sv
// Bank of double-buffered configuration registers with a host port, a bulk
// load port, an update-control register at address NUM_REGS and a gated
// page-erase strobe. Assumes DATA_W >= 3. Addresses above NUM_REGS are unused.
module dbuf_cfg_bank
    import dbuf_cfg_pkg::*;
#(
    parameter  int NUM_REGS = 8,
    parameter  int DATA_W   = 8,
    parameter  int PAGE_W   = 4,
    localparam int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    input  logic                       dl_wr,
    input  logic [ADDR_W-1:0]          dl_addr,
    input  logic [DATA_W-1:0]          dl_data,
    input  logic                       dl_commit,
    input  logic                       erase_cmd,
    input  logic [PAGE_W-1:0]          erase_page,
    output logic                       erase_go,
    output logic [PAGE_W-1:0]          erase_page_q,
    output logic [NUM_REGS*DATA_W-1:0] cfg_active
);

    localparam int CTRL_ADDR = NUM_REGS;

    upd_ctrl_t                  ctrl;
    logic                       commit_pulse;
    logic                       commit_now;
    logic                       transparent;
    logic                       erase_en;
    logic                       ctrl_hit;
    logic [CTRL_BITS-1:0]       ctrl_rd;
    logic [DATA_W-1:0]          back_arr [NUM_REGS];
    logic [NUM_REGS*DATA_W-1:0] front_flat;

    assign ctrl_hit    = host_wr && (host_addr == ADDR_W'(CTRL_ADDR));
    assign commit_now  = commit_pulse || dl_commit;
    assign transparent = ctrl.transparent;
    assign erase_en    = ctrl.erase_en;

    dbuf_upd_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_hit),
        .ctrl_d       (host_wdata[CTRL_BITS-1:0]),
        .ctrl_q       (ctrl),
        .commit_pulse (commit_pulse),
        .ctrl_rd      (ctrl_rd)
    );

    // One stage pair per configuration register.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic host_hit;
        logic load_hit;
        assign host_hit = host_wr && (host_addr == ADDR_W'(gi));
        assign load_hit = dl_wr && (dl_addr == ADDR_W'(gi));

        dbuf_stage_pair #(.DATA_W(DATA_W)) u_pair (
            .clk         (clk),
            .rst_n       (rst_n),
            .host_we     (host_hit),
            .host_d      (host_wdata),
            .load_we     (load_hit),
            .load_d      (dl_data),
            .commit      (commit_now),
            .transparent (transparent),
            .front_q     (front_flat[gi*DATA_W +: DATA_W]),
            .back_q      (back_arr[gi])
        );

        assign cfg_active[gi*DATA_W +: DATA_W] = back_arr[gi];
    end

    dbuf_erase_gate #(.PAGE_W(PAGE_W)) u_erase (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_en (erase_en),
        .req      (erase_cmd),
        .req_page (erase_page),
        .go       (erase_go),
        .go_page  (erase_page_q)
    );

    // Read mux: back stage, control view, or zero for unused addresses.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(CTRL_ADDR)) begin
            host_rdata[CTRL_BITS-1:0] = ctrl_rd;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (host_addr == ADDR_W'(i)) host_rdata = back_arr[i];
            end
        end
    end

endmodule

// File: rtl/dbuf_cfg_bank_chk.sv
// Property checker for dbuf_cfg_bank, attached with bind. It watches the
// ports and the internal front stages, commit pulse and control state.
module dbuf_cfg_bank_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 4,
    parameter int ADDR_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       host_wr,
    input logic [ADDR_W-1:0]          host_addr,
    input logic [DATA_W-1:0]          host_wdata,
    input logic [DATA_W-1:0]          host_rdata,
    input logic                       erase_cmd,
    input logic [PAGE_W-1:0]          erase_page,
    input logic                       erase_go,
    input logic [PAGE_W-1:0]          erase_page_q,
    input logic [NUM_REGS*DATA_W-1:0] cfg_active,
    input logic [NUM_REGS*DATA_W-1:0] front_flat,
    input logic                       commit_now,
    input logic                       commit_pulse,
    input logic                       transparent,
    input logic                       erase_en
);

    logic ctrl_commit_wr;
    assign ctrl_commit_wr = host_wr && (host_addr == ADDR_W'(NUM_REGS)) && host_wdata[1];

    // R2
    transp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && transparent && (host_addr < ADDR_W'(NUM_REGS)))
        |=> cfg_active[$past(host_addr)*DATA_W +: DATA_W] == $past(host_wdata));

    // R3
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !transparent && !commit_now) |=> $stable(cfg_active));

    // R4
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_now && !(host_wr && transparent)) |=> cfg_active == $past(front_flat));

    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pulse && !ctrl_commit_wr) |=> !commit_pulse);

    // R5
    commit_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_W'(NUM_REGS)) |-> !host_rdata[1]);

    // R8
    erase_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_cmd && !erase_en) |=> (!erase_go && erase_page_q == '0));

    // R8
    erase_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_cmd && erase_en) |=> (erase_go && erase_page_q == $past(erase_page)));

endmodule

bind dbuf_cfg_bank dbuf_cfg_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .erase_cmd    (erase_cmd),
    .erase_page   (erase_page),
    .erase_go     (erase_go),
    .erase_page_q (erase_page_q),
    .cfg_active   (cfg_active),
    .front_flat   (front_flat),
    .commit_now   (commit_now),
    .commit_pulse (commit_pulse),
    .transparent  (transparent),
    .erase_en     (erase_en)
);

// File: tb/test_dbuf_cfg_bank.sv
`timescale 1ns/1ps
module test_dbuf_cfg_bank;

    localparam int NR = 8;
    localparam int DW = 8;
    localparam int PW = 4;
    localparam int AW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [DW-1:0]  host_wdata = '0;
    logic [DW-1:0]  host_rdata;
    logic           dl_wr = 1'b0;
    logic [AW-1:0]  dl_addr = '0;
    logic [DW-1:0]  dl_data = '0;
    logic           dl_commit = 1'b0;
    logic           erase_cmd = 1'b0;
    logic [PW-1:0]  erase_page = '0;
    logic           erase_go;
    logic [PW-1:0]  erase_page_q;
    logic [NR*DW-1:0] cfg_active;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state built from the requirements
    logic [DW-1:0] fm [NR];
    logic [DW-1:0] bm [NR];
    logic tm, em, pm, egm;
    logic [PW-1:0] epm;

    always #4 clk = ~clk;

    dbuf_cfg_bank #(.NUM_REGS(NR), .DATA_W(DW), .PAGE_W(PW)) i_dbuf_cfg_bank (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .dl_wr(dl_wr), .dl_addr(dl_addr), .dl_data(dl_data), .dl_commit(dl_commit),
        .erase_cmd(erase_cmd), .erase_page(erase_page),
        .erase_go(erase_go), .erase_page_q(erase_page_q),
        .cfg_active(cfg_active)
    );

    function automatic logic [NR*DW-1:0] exp_active();
        logic [NR*DW-1:0] v;
        for (int i = 0; i < NR; i++) v[i*DW +: DW] = bm[i];
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        if (int'(a) < NR) v = bm[a];
        else if (int'(a) == NR) begin v[0] = tm; v[2] = em; end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [NR*DW-1:0] act,
                       input logic [NR*DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin fm[i] = '0; bm[i] = '0; end
        tm = 0; em = 0; pm = 0; egm = 0; epm = '0;
    endtask

    // Steps the reference model with the inputs driven for this edge.
    task automatic model_step();
        logic cn;
        logic [DW-1:0] of [NR];
        cn = pm || dl_commit;
        for (int i = 0; i < NR; i++) of[i] = fm[i];
        for (int i = 0; i < NR; i++) begin
            logic hw, lw;
            hw = host_wr && (int'(host_addr) == i);
            lw = dl_wr && (int'(dl_addr) == i);
            if (hw) fm[i] = host_wdata;
            else if (lw) fm[i] = dl_data;
            if (hw && tm) bm[i] = host_wdata;
            else if (cn) bm[i] = of[i];
        end
        egm = erase_cmd && em;
        epm = (erase_cmd && em) ? erase_page : '0;
        if (host_wr && int'(host_addr) == NR) begin
            pm = host_wdata[1]; tm = host_wdata[0]; em = host_wdata[2];
        end else pm = 0;
    endtask

    // One cycle: drive at falling edge, model at rising edge, compare after.
    task automatic cyc(input string tag,
                       input logic hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                       input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic dc, input logic ec, input logic [PW-1:0] ep);
        host_wr = hw; host_addr = ha; host_wdata = hd;
        dl_wr = lw; dl_addr = la; dl_data = ld; dl_commit = dc;
        erase_cmd = ec; erase_page = ep;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " cfg_active"}, cfg_active, exp_active());
        chk({"R9 rdata ", tag}, {{(NR*DW-DW){1'b0}}, host_rdata},
            {{(NR*DW-DW){1'b0}}, exp_rdata(host_addr)});
        chk({"R8 erase ", tag}, {{(NR*DW-PW-1){1'b0}}, erase_go, erase_page_q},
            {{(NR*DW-PW-1){1'b0}}, egm, epm});
    endtask

    task automatic idle(input string tag, input logic [AW-1:0] ra);
        cyc(tag, 0, ra, '0, 0, '0, '0, 0, 0, '0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        // R1: dirty the state first, then reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R2 prime", 1, 4'(NR), 8'h05, 0, '0, '0, 0, 0, '0);
        cyc("R2 prime", 1, 4'd3, 8'hAA, 0, '0, '0, 0, 0, '0);
        rst_n = 1'b0;
        host_wr = 0; erase_cmd = 1; erase_page = 4'h7;
        @(posedge clk); @(posedge clk);
        model_reset();
        @(negedge clk);
        chk("R1 reset cfg_active", cfg_active, '0);
        chk("R1 reset erase_go", {63'b0, erase_go}, '0);
        erase_cmd = 0;
        rst_n = 1'b1;
        idle("R1 ctrl read", 4'(NR));

        // R3: held write leaves active config alone
        cyc("R3 held write", 1, 4'd2, 8'h3C, 0, '0, '0, 0, 0, '0);
        idle("R3 held read", 4'd2);
        // R4/R5: commit via control bit 1, readback of bit1 is 0
        cyc("R4 commit req", 1, 4'(NR), 8'h02, 0, '0, '0, 0, 0, '0);
        idle("R5 bit1 reads 0", 4'(NR));
        idle("R4 after commit", 4'd2);
        // R6: held write on the commit edge
        cyc("R6 stage", 1, 4'd5, 8'h11, 0, '0, '0, 0, 0, '0);
        cyc("R6 commit req", 1, 4'(NR), 8'h02, 0, '0, '0, 0, 0, '0);
        cyc("R6 collide", 1, 4'd5, 8'h22, 0, '0, '0, 0, 0, '0);
        idle("R6 old value active", 4'd5);
        cyc("R6 recommit", 1, 4'(NR), 8'h02, 0, '0, '0, 0, 0, '0);
        idle("R6 new value active", 4'd5);
        // R2: transparent mode
        cyc("R2 set transparent", 1, 4'(NR), 8'h01, 0, '0, '0, 0, 0, '0);
        cyc("R2 write through", 1, 4'd7, 8'hE7, 0, '0, '0, 0, 0, '0);
        // R7: load port, collision, dl_commit
        cyc("R7 held mode", 1, 4'(NR), 8'h00, 0, '0, '0, 0, 0, '0);
        cyc("R7 load", 0, '0, '0, 1, 4'd1, 8'h91, 0, 0, '0);
        cyc("R7 collide", 1, 4'd0, 8'h40, 1, 4'd0, 8'h50, 0, 0, '0);
        cyc("R7 dl_commit", 0, 4'd0, '0, 0, '0, '0, 1, 0, '0);
        idle("R7 read", 4'd1);
        // R9: unused address write has no effect
        cyc("R9 unused write", 1, 4'(NR + 3), 8'hFF, 0, '0, '0, 0, 0, '0);
        idle("R9 unused read", 4'(NR + 3));
        // R8: erase gated off then on
        cyc("R8 erase blocked", 0, '0, '0, 0, '0, '0, 0, 1, 4'h9);
        cyc("R8 enable", 1, 4'(NR), 8'h04, 0, '0, '0, 0, 0, '0);
        cyc("R8 erase pass", 0, '0, '0, 0, '0, '0, 0, 1, 4'hC);
        idle("R8 erase done", 4'(NR));

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic hw, lw, dc, ec;
            logic [AW-1:0] ha, la;
            logic [DW-1:0] hd;
            hw = ($urandom_range(0, 1) == 1);
            ha = ($urandom_range(0, 4) == 0) ? 4'(NR) : 4'($urandom_range(0, NR + 2));
            hd = 8'($urandom);
            lw = ($urandom_range(0, 2) == 0);
            la = 4'($urandom_range(0, NR - 1));
            dc = ($urandom_range(0, 19) == 0);
            ec = ($urandom_range(0, 4) == 0);
            cyc("R2/R3/R4/R6/R7 random", hw, ha, hd, lw, la, 8'($urandom), dc, ec,
                4'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule